// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that a core uses for lock-free read-modify-write sequences built from a load-linked / store-conditional pair. A load-linked forms its effective address, requests the read and, when the address is cacheable and coherent, arms a link on that word. A later store-conditional to the same word is allowed to write memory only while the link is still intact, and the block returns a flag of 1 or 0 to be written into the store's own data register.

The link is dropped by a write from another agent to any byte of the reserved word, by eviction of the cache line that holds it, by a return-from-exception, and by every store-conditional whether it succeeds or not. A new load-linked replaces an older reservation. The register file supplies the base and data values; the block names the base register it needs through a combinational select output and presents its memory request and writeback one clock after the instruction is issued.

Top module: `llsc_monitor`

## Requirements
- R1: The 32-bit instruction is read as opcode in bits 31:26, base register in 25:21, data register in 20:16 and offset in 15:0; opcode 6'h30 is load-linked, 6'h38 is store-conditional, and any other opcode produces no request, no writeback and no change to the link. `base_sel` always equals bits 25:21 of the presented instruction.
- R2: The effective address is `base_val` plus the offset sign-extended to XLEN bits, and it appears on `mem_addr` for both operations.
- R3: A load-linked raises `mem_rd_en` with `dst_reg` set to its data register; when `addr_cacheable` is 1 it arms the link on the word address (bits XLEN-1:2), replacing any earlier link; when 0 it leaves no link.
- R4: A store-conditional succeeds only when the link is armed, the word address matches, the address is cacheable and no clearing event arrives in the same cycle; on success `mem_wr_en` is 1, `mem_wdata` carries `rt_val`, `sc_done` is 1 and `sc_flag` is 1.
- R5: A failed store-conditional leaves `mem_wr_en` at 0 and `mem_wdata` at 0, and reports `sc_done` 1 with `sc_flag` 0 to its data register.
- R6: A snooped write whose address falls in any byte of the reserved word clears the link; a write to another word does not.
- R7: An eviction whose address lies in the same LINE_BYTES-aligned line as the reserved word clears the link; an eviction of another line does not.
- R8: `rfe_exec` clears the link unconditionally.
- R9: Every store-conditional clears the link, so a second one without a new load-linked fails.
- R10: Synchronous active-high reset clears the link and drives every registered output to 0.
- R11: A clearing event in the same cycle as a load-linked wins (no link results); a clearing event in the same cycle as a store-conditional makes it fail.
- R12: Results appear one clock after issue; in a cycle with no recognised operation all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| issue_instr | input | 32 | Instruction word |
| base_val | input | XLEN | Value of the base register named by `base_sel` |
| rt_val | input | XLEN | Value of the data register (store data) |
| addr_cacheable | input | 1 | Effective address is cacheable and coherent |
| rfe_exec | input | 1 | Return-from-exception executes this cycle |
| snoop_wr_valid | input | 1 | Another agent writes memory this cycle |
| snoop_wr_addr | input | XLEN | Byte address of the snooped write |
| evict_valid | input | 1 | A cache line leaves the cache this cycle |
| evict_addr | input | XLEN | Any byte address inside the evicted line |
| base_sel | output | 5 | Base register index for the register-file read |
| mem_rd_en | output | 1 | Load-linked read request |
| mem_wr_en | output | 1 | Successful store-conditional write |
| mem_addr | output | XLEN | Effective address of the request |
| mem_wdata | output | XLEN | Store data on success, else 0 |
| dst_reg | output | 5 | Data register to receive load data or the flag |
| sc_done | output | 1 | A store-conditional result is being returned |
| sc_flag | output | 1 | 1 for success, 0 for failure |

## Verification
The hardest situation to reach from the ports is a clearing event landing on exactly the reserved word or line, because random addresses almost never collide with a 30-bit word index. The stimulus draws base values from a tiny pool and offsets from a handful of small steps, and aims snoop and eviction addresses at the last load-linked address plus a small jitter, so hits, near misses across a word or line boundary and same-cycle collisions with a store-conditional all occur often. Directed cases first pin each clearing source alone and the same-cycle priority before the random run.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam logic [5:0] OPC_LL = 6'h30;
    localparam logic [5:0] OPC_SC = 6'h38;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LL   = 2'd1,
        OP_SC   = 2'd2
    } llsc_op_e;

    typedef struct packed {
        logic [5:0]  opc;
        logic [4:0]  base;
        logic [4:0]  rt;
        logic [15:0] imm;
    } llsc_instr_t;

    function automatic llsc_op_e classify(input logic valid, input logic [5:0] opc);
        if (!valid)          return OP_NONE;
        else if (opc == OPC_LL) return OP_LL;
        else if (opc == OPC_SC) return OP_SC;
        else                 return OP_NONE;
    endfunction

endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
    import llsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            issue_valid,
    input  logic [31:0]     issue_instr,
    input  logic [XLEN-1:0] base_val,
    output llsc_op_e        op,
    output logic [4:0]      base_idx,
    output logic [4:0]      rt_idx,
    output logic [XLEN-1:0] eff_addr
);
    localparam int IMM_W = 16;

    llsc_instr_t fields;
    logic [XLEN-1:0] imm_ext;

    always_comb begin
        fields   = llsc_instr_t'(issue_instr);
        op       = classify(issue_valid, fields.opc);
        base_idx = fields.base;
        rt_idx   = fields.rt;
        imm_ext  = {{(XLEN-IMM_W){fields.imm[IMM_W-1]}}, fields.imm};
        eff_addr = base_val + imm_ext;
    end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int XLEN       = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm_req,
    input  logic [XLEN-3:0] arm_word,
    input  logic            drop_req,
    input  logic            rfe_exec,
    input  logic            snoop_wr_valid,
    input  logic [XLEN-1:0] snoop_wr_addr,
    input  logic            evict_valid,
    input  logic [XLEN-1:0] evict_addr,
    output logic            link_valid,
    output logic [XLEN-3:0] link_word,
    output logic            kill_now
);
    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int WORD_W     = XLEN - 2;
    localparam int LINE_LSB   = LINE_SHIFT - 2;

    logic snoop_hit, evict_hit;
    logic unused_low_bits;

    assign unused_low_bits = ^{snoop_wr_addr[1:0], evict_addr[LINE_SHIFT-1:0]};

    always_comb begin
        snoop_hit = snoop_wr_valid && link_valid &&
                    (snoop_wr_addr[XLEN-1:2] == link_word);
        evict_hit = evict_valid && link_valid &&
                    (evict_addr[XLEN-1:LINE_SHIFT] == link_word[WORD_W-1:LINE_LSB]);
        kill_now  = rfe_exec || snoop_hit || evict_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_valid <= 1'b0;
            link_word  <= '0;
        end else if (kill_now || drop_req) begin
            link_valid <= 1'b0;
        end else if (arm_req) begin
            link_valid <= 1'b1;
            link_word  <= arm_word;
        end
    end
endmodule

// File: rtl/llsc_respond.sv
module llsc_respond
    import llsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  llsc_op_e        op,
    input  logic [XLEN-1:0] eff_addr,
    input  logic [4:0]      rt_idx,
    input  logic [XLEN-1:0] rt_val,
    input  logic            addr_cacheable,
    input  logic            link_valid,
    input  logic [XLEN-3:0] link_word,
    input  logic            kill_now,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [4:0]      dst_reg,
    output logic            sc_done,
    output logic            sc_flag
);
    logic is_ll, is_sc, any_op, link_ok, sc_pass;

    always_comb begin
        is_ll   = (op == OP_LL);
        is_sc   = (op == OP_SC);
        any_op  = is_ll || is_sc;
        link_ok = link_valid && !kill_now && addr_cacheable &&
                  (eff_addr[XLEN-1:2] == link_word);
        sc_pass = is_sc && link_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            dst_reg   <= '0;
            sc_done   <= 1'b0;
            sc_flag   <= 1'b0;
        end else begin
            mem_rd_en <= is_ll;
            mem_wr_en <= sc_pass;
            mem_addr  <= any_op ? eff_addr : '0;
            mem_wdata <= sc_pass ? rt_val : '0;
            dst_reg   <= any_op ? rt_idx : 5'd0;
            sc_done   <= is_sc;
            sc_flag   <= sc_pass;
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  logic [31:0]     issue_instr,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic            addr_cacheable,
    input  logic            rfe_exec,
    input  logic            snoop_wr_valid,
    input  logic [XLEN-1:0] snoop_wr_addr,
    input  logic            evict_valid,
    input  logic [XLEN-1:0] evict_addr,
    output logic [4:0]      base_sel,
    output logic            mem_rd_en,
    output logic            mem_wr_en,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic [4:0]      dst_reg,
    output logic            sc_done,
    output logic            sc_flag
);
    llsc_op_e        op;
    logic [4:0]      rt_idx;
    logic [XLEN-1:0] eff_addr;
    logic            link_valid;
    logic [XLEN-3:0] link_word;
    logic            kill_now;
    logic            arm_req, drop_req;

    assign arm_req  = (op == OP_LL) && addr_cacheable;
    assign drop_req = (op == OP_SC);

    llsc_decode #(.XLEN(XLEN)) u_decode (
        .issue_valid (issue_valid),
        .issue_instr (issue_instr),
        .base_val    (base_val),
        .op          (op),
        .base_idx    (base_sel),
        .rt_idx      (rt_idx),
        .eff_addr    (eff_addr)
    );

    llsc_resv #(.XLEN(XLEN), .LINE_BYTES(LINE_BYTES)) u_resv (
        .clk            (clk),
        .rst            (rst),
        .arm_req        (arm_req),
        .arm_word       (eff_addr[XLEN-1:2]),
        .drop_req       (drop_req),
        .rfe_exec       (rfe_exec),
        .snoop_wr_valid (snoop_wr_valid),
        .snoop_wr_addr  (snoop_wr_addr),
        .evict_valid    (evict_valid),
        .evict_addr     (evict_addr),
        .link_valid     (link_valid),
        .link_word      (link_word),
        .kill_now       (kill_now)
    );

    llsc_respond #(.XLEN(XLEN)) u_respond (
        .clk            (clk),
        .rst            (rst),
        .op             (op),
        .eff_addr       (eff_addr),
        .rt_idx         (rt_idx),
        .rt_val         (rt_val),
        .addr_cacheable (addr_cacheable),
        .link_valid     (link_valid),
        .link_word      (link_word),
        .kill_now       (kill_now),
        .mem_rd_en      (mem_rd_en),
        .mem_wr_en      (mem_wr_en),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .dst_reg        (dst_reg),
        .sc_done        (sc_done),
        .sc_flag        (sc_flag)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            issue_valid,
    input logic [5:0]      issue_opc,
    input logic            rfe_exec,
    input logic            snoop_wr_valid,
    input logic [XLEN-3:0] snoop_word,
    input logic            link_valid,
    input logic [XLEN-3:0] link_word,
    input logic            mem_rd_en,
    input logic            mem_wr_en,
    input logic [XLEN-1:0] mem_addr,
    input logic            sc_done,
    input logic            sc_flag
);
    logic sc_issue;
    assign sc_issue = issue_valid && (issue_opc == OPC_SC);

    AST_WRITE_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(link_valid)); // R4
    AST_WRITE_WORD_MATCH: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_addr[XLEN-1:2] == $past(link_word))); // R4
    AST_FLAG_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        sc_done |-> (sc_flag == mem_wr_en)); // R5
    AST_NO_FLAG_WITHOUT_SC: assert property (@(posedge clk) disable iff (rst)
        !sc_done |-> (!sc_flag && !mem_wr_en)); // R5
    AST_RFE_DROPS_LINK: assert property (@(posedge clk) disable iff (rst)
        rfe_exec |=> !link_valid); // R8
    AST_SC_DROPS_LINK: assert property (@(posedge clk) disable iff (rst)
        sc_issue |=> !link_valid); // R9
    AST_SNOOP_DROPS_LINK: assert property (@(posedge clk) disable iff (rst)
        (snoop_wr_valid && link_valid && (snoop_word == link_word)) |=> !link_valid); // R6
    AST_SC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sc_issue |=> sc_done); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!mem_rd_en && !mem_wr_en && !sc_done)); // R12
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en)); // R12
endmodule

bind llsc_monitor llsc_monitor_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .issue_valid    (issue_valid),
    .issue_opc      (issue_instr[31:26]),
    .rfe_exec       (rfe_exec),
    .snoop_wr_valid (snoop_wr_valid),
    .snoop_word     (snoop_wr_addr[XLEN-1:2]),
    .link_valid     (link_valid),
    .link_word      (link_word),
    .mem_rd_en      (mem_rd_en),
    .mem_wr_en      (mem_wr_en),
    .mem_addr       (mem_addr),
    .sc_done        (sc_done),
    .sc_flag        (sc_flag)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int XLEN = 32;
    localparam int VW   = 78;

    logic            clk = 1'b0;
    logic            rst;
    logic            issue_valid;
    logic [31:0]     issue_instr;
    logic [XLEN-1:0] base_val, rt_val;
    logic            addr_cacheable, rfe_exec;
    logic            snoop_wr_valid, evict_valid;
    logic [XLEN-1:0] snoop_wr_addr, evict_addr;
    logic [4:0]      base_sel, dst_reg;
    logic            mem_rd_en, mem_wr_en, sc_done, sc_flag;
    logic [XLEN-1:0] mem_addr, mem_wdata;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model of the link
    logic        m_link;
    logic [29:0] m_word;

    // stimulus knobs: kind 0 idle, 1 LL, 2 SC, 3 other opcode
    int          s_kind;
    logic [31:0] s_base, s_data, s_snp, s_ev;
    logic [15:0] s_off;
    logic [4:0]  s_bidx, s_ridx;
    logic        s_cach, s_rfe, s_snpv, s_evv;

    always #10 clk = ~clk;

    llsc_monitor u_llsc_monitor (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .base_val(base_val), .rt_val(rt_val), .addr_cacheable(addr_cacheable),
        .rfe_exec(rfe_exec), .snoop_wr_valid(snoop_wr_valid), .snoop_wr_addr(snoop_wr_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .base_sel(base_sel),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dst_reg(dst_reg), .sc_done(sc_done), .sc_flag(sc_flag)
    );

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_knobs();
        s_kind = 0; s_base = 32'h1000; s_off = 16'h0; s_data = 32'h0;
        s_bidx = 5'd1; s_ridx = 5'd2; s_cach = 1'b1; s_rfe = 1'b0;
        s_snpv = 1'b0; s_snp = 32'h0; s_evv = 1'b0; s_ev = 32'h0;
    endtask

    task automatic drive_idle();
        issue_valid = 1'b0; issue_instr = 32'h0; base_val = '0; rt_val = '0;
        addr_cacheable = 1'b0; rfe_exec = 1'b0; snoop_wr_valid = 1'b0;
        snoop_wr_addr = '0; evict_valid = 1'b0; evict_addr = '0;
    endtask

    // apply knobs at negedge, check just after the following posedge
    task automatic apply(input string tag_in);
        logic [5:0]  opc;
        logic [31:0] ea;
        logic        is_ll, is_sc, kill, pass;
        logic [VW-1:0] exp;
        string       tag;
        opc = (s_kind == 1) ? 6'h30 : (s_kind == 2) ? 6'h38 : 6'h23;
        issue_valid    = (s_kind != 0);
        issue_instr    = {opc, s_bidx, s_ridx, s_off};
        base_val       = s_base;
        rt_val         = s_data;
        addr_cacheable = s_cach;
        rfe_exec       = s_rfe;
        snoop_wr_valid = s_snpv;
        snoop_wr_addr  = s_snp;
        evict_valid    = s_evv;
        evict_addr     = s_ev;
        ea    = ea_of(s_base, s_off);
        is_ll = (s_kind == 1);
        is_sc = (s_kind == 2);
        kill  = s_rfe || (s_snpv && m_link && s_snp[31:2] == m_word) ||
                (s_evv && m_link && s_ev[31:5] == m_word[29:3]);
        pass  = is_sc && m_link && !kill && s_cach && (ea[31:2] == m_word);
        exp   = {is_ll, pass, (is_ll || is_sc) ? ea : 32'h0, pass ? s_data : 32'h0,
                 (is_ll || is_sc) ? s_ridx : 5'd0, is_sc, pass, s_bidx};
        if (tag_in != "") tag = tag_in;
        else if (kill)    tag = "R6/R7/R8";
        else if (is_sc)   tag = "R4/R5";
        else if (is_ll)   tag = "R3";
        else              tag = "R12";
        if (kill || is_sc) m_link = 1'b0;
        else if (is_ll && s_cach) begin m_link = 1'b1; m_word = ea[31:2]; end
        @(posedge clk); #1;
        check(tag, {mem_rd_en, mem_wr_en, mem_addr, mem_wdata, dst_reg, sc_done, sc_flag, base_sel}, exp);
        drive_idle();
        @(negedge clk);
    endtask

    task automatic op_ll(input logic [31:0] b, input logic [15:0] o, input string tag);
        idle_knobs(); s_kind = 1; s_base = b; s_off = o; s_ridx = 5'd7; apply(tag);
    endtask

    task automatic op_sc(input logic [31:0] b, input logic [15:0] o, input string tag);
        idle_knobs(); s_kind = 2; s_base = b; s_off = o; s_ridx = 5'd9;
        s_data = 32'hCAFE_0000 | b; apply(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        m_link = 1'b0; m_word = '0;
        drive_idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset outputs", {mem_rd_en, mem_wr_en, mem_addr, mem_wdata, dst_reg, sc_done, sc_flag, 5'd0},
              {VW{1'b0}});
        op_sc(32'h1000, 16'h0, "R10 no link after reset");
        op_ll(32'h1000, 16'h8, "R3 LL request");
        op_sc(32'h1004, 16'h4, "R2/R4 SC success");
        op_sc(32'h1008, 16'h0, "R9 second SC fails");
        // snoop to another byte of the same word
        op_ll(32'h1000, 16'h0, "R3");
        idle_knobs(); s_snpv = 1'b1; s_snp = 32'h1003; apply("R6 snoop same word");
        op_sc(32'h1000, 16'h0, "R6 SC after snoop fails");
        op_ll(32'h1000, 16'h0, "R3");
        idle_knobs(); s_snpv = 1'b1; s_snp = 32'h1004; apply("R6 snoop other word");
        op_sc(32'h1000, 16'h0, "R6 SC survives other word");
        // eviction
        op_ll(32'h1008, 16'h0, "R3");
        idle_knobs(); s_evv = 1'b1; s_ev = 32'h101C; apply("R7 evict same line");
        op_sc(32'h1008, 16'h0, "R7 SC after evict fails");
        op_ll(32'h1008, 16'h0, "R3");
        idle_knobs(); s_evv = 1'b1; s_ev = 32'h1020; apply("R7 evict other line");
        op_sc(32'h1008, 16'h0, "R7 SC survives other line");
        // return from exception
        op_ll(32'h1000, 16'h0, "R3");
        idle_knobs(); s_rfe = 1'b1; apply("R8 rfe");
        op_sc(32'h1000, 16'h0, "R8 SC after rfe fails");
        // uncached
        idle_knobs(); s_kind = 1; s_cach = 1'b0; apply("R3 uncached LL");
        op_sc(32'h1000, 16'h0, "R3 uncached LL leaves no link");
        op_ll(32'h1000, 16'h0, "R3");
        idle_knobs(); s_kind = 2; s_cach = 1'b0; apply("R4 uncached SC fails");
        // replacement and mismatch
        op_ll(32'h1000, 16'h0, "R3");
        op_ll(32'h2000, 16'h0, "R3 replace");
        op_sc(32'h1000, 16'h0, "R3 old link replaced");
        op_ll(32'h1000, 16'h0, "R3");
        op_sc(32'h1000, 16'h4, "R4 word mismatch fails");
        // same-cycle priority
        idle_knobs(); s_kind = 1; s_rfe = 1'b1; apply("R11 LL with rfe");
        op_sc(32'h1000, 16'h0, "R11 kill beats LL");
        op_ll(32'h1000, 16'h0, "R3");
        idle_knobs(); s_kind = 2; s_snpv = 1'b1; s_snp = 32'h1002; apply("R11 SC with snoop fails");
        // negative offset
        op_ll(32'h2000, 16'hFFF0, "R2 negative offset");
        op_sc(32'h1FE0, 16'h0010, "R2 SC on 0x1FF0");
        // unrelated opcode
        idle_knobs(); s_kind = 3; s_bidx = 5'd17; apply("R1 other opcode ignored");
        op_ll(32'h3000, 16'h0, "R3");
        idle_knobs(); s_kind = 3; s_base = 32'h3000; apply("R1 other opcode ignored");
        op_sc(32'h3000, 16'h0, "R1 link kept over other opcode");

        // constrained random
        void'($urandom(32'd731));
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] pool [4];
            logic [15:0] offs [5];
            logic [31:0] tgt;
            pool[0] = 32'h1000; pool[1] = 32'h1004; pool[2] = 32'h101C; pool[3] = 32'h1020;
            offs[0] = 16'h0; offs[1] = 16'h4; offs[2] = 16'hFFFC; offs[3] = 16'h2; offs[4] = 16'h8;
            idle_knobs();
            s_kind = int'($urandom_range(0, 3));
            if (s_kind == 3 && $urandom_range(0, 1) == 0) s_kind = 2;
            s_base = pool[$urandom_range(0, 3)];
            s_off  = offs[$urandom_range(0, 4)];
            s_data = $urandom;
            s_bidx = 5'($urandom);
            s_ridx = 5'($urandom);
            s_cach = ($urandom_range(0, 9) != 0);
            s_rfe  = ($urandom_range(0, 29) == 0);
            tgt    = {m_word, 2'b00};
            s_snpv = ($urandom_range(0, 5) == 0);
            s_snp  = tgt + 32'($urandom_range(0, 7)) - 32'd2;
            s_evv  = ($urandom_range(0, 7) == 0);
            s_ev   = tgt + 32'($urandom_range(0, 63)) - 32'd16;
            apply("");
        end
        summary();
    end
endmodule